// File: doc/BRIEF.md
# Timer with Shared Prescaler and Phase-Sampled Clock Input

An 8-bit up-counting timer that advances on the internal instruction clock or on edges of an external clock pin. The instruction cycle is four oscillator periods long. Two phase strobes mark its second and fourth periods (Q2 and Q4). One 8-bit prescaler counter serves a single owner at a time. It either divides the timer's count source or acts as a postscaler on a watchdog tick input. Whichever side does not own it runs at 1:1.

External clock edges pass through a two-flop synchronizer. The timer's count signal is then sampled on the Q2 and Q4 edges, and the timer steps only on a Q4 edge. That count signal is the synchronized pin level, or the selected prescaler tap when the prescaler belongs to the timer. A write to the timer loads the new value and holds it for two instruction cycles. A wrap from 0xFF to 0x00 produces a one-cycle overflow pulse. The prescaler cannot be read or written. It is cleared by a timer write or by a watchdog clear, depending on which side owns it.

Top module: `timer8_shared_scaler`

## Requirements
- R1: While reset is low, and at its release, the timer reads 0 and the overflow and watchdog output are low. The prescaler count resets to zero. The control register resets to 6'b001111: ratio 7, owned by the watchdog, internal source, rising edge.
- R2: A one-cycle `ctrl_wr` loads `ctrl_data` into the control register. The fields are: bits [2:0] ratio r; bit 3 owner (0 timer, 1 watchdog); bit 4 source (0 instruction clock, 1 external pin); bit 5 edge (0 rising, 1 falling).
- R3: With the internal source and the prescaler owned by the watchdog, the timer steps by exactly 1 on every Q4 edge outside a write hold. It only ever steps by +1, with 0xFF wrapping to 0x00.
- R4: When the timer owns the prescaler, the timer steps once per 2^(r+1) source events (instruction cycles or selected pin edges), for r = 0..7.
- R5: A `tmr_wr` loads `tmr_wdata` on that edge and suppresses the next two Q4 steps. With the internal 1:1 source, the value 4n edges after the write edge is wdata+n-2 for n >= 2, and wdata for n = 1.
- R6: A timer write clears the prescaler count only while the timer owns it. While the watchdog owns it, a timer write leaves the postscaler count unchanged.
- R7: With the watchdog as owner, `wdt_tick_out` pulses once per 2^r `wdt_tick_in` pulses, the first at the 2^r-th pulse after a clear. With the timer as owner it mirrors every input pulse. The output always follows the input by one clock.
- R8: `wdt_clr` clears the prescaler only while the watchdog owns it. While the timer owns it, `wdt_clr` has no effect on the timer's rate.
- R9: With the external source and no prescaler, every selected pin edge whose high and low levels each last at least 2 clocks advances the timer exactly once, for either edge setting. With the internal source, pin activity has no effect.
- R10: With the external source and no prescaler, edge 0 is the first clock edge that captures a new pin level. The timer changes at edge 2, 3, 4 or 5 when edge 2 is a Q4, Q3, Q2 or Q1 phase edge respectively.
- R11: A one-clock pin pulse whose synchronized level is present only at a Q1 or Q3 edge is not counted.
- R12: A step from 0xFF to 0x00 raises `tmr_ovf` for exactly one clock, while the value reads 0x00. No other event raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ph_q2 | input | 1 | High during the second oscillator period of each instruction cycle |
| ph_q4 | input | 1 | High during the fourth oscillator period of each instruction cycle |
| ext_clk_in | input | 1 | External clock pin, asynchronous |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 6 | Control register write data |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| wdt_tick_in | input | 1 | Watchdog tick to be postscaled |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wdt_tick_out | output | 1 | Postscaled watchdog tick |
| tmr_value | output | 8 | Current timer value |
| tmr_ovf | output | 1 | One-cycle overflow pulse |

## Verification
A prescaler count left uncleared after a write or a watchdog clear shows up within one prescale period. It appears as a timer step where none was due, or as a watchdog output pulse that comes early. A wrong sampler or synchronizer state moves the timer step by whole clocks, which the per-phase latency checks reveal on the next pin edge. It can also let a short pulse be counted, or make a pulse count twice. A wrong hold count moves the first step after a write, which shows within three instruction cycles.

// File: rtl/tsp_pkg.sv
// Shared types for the timer with shared prescaler.
// Assumes the prescaler width is a power of two.
package tsp_pkg;
    localparam int PRE_BITS = 8;
    localparam int RATIO_W  = $clog2(PRE_BITS);
    localparam int CFG_W    = RATIO_W + 3;

    typedef struct packed {
        logic               edge_fall;  // 1: count falling pin edges
        logic               src_ext;    // 1: external pin is the source
        logic               to_wdt;     // 1: prescaler owned by watchdog
        logic [RATIO_W-1:0] ratio;      // prescale select
    } cfg_t;

    localparam cfg_t CFG_RESET = '{edge_fall: 1'b0, src_ext: 1'b0,
                                   to_wdt: 1'b1, ratio: '1};
endpackage

// File: rtl/tsp_ext_sync.sv
// External pin synchronizer with polarity select and edge detector.
// Output lvl is the synchronized pin, inverted when falling edges are
// selected. rise pulses for one clock when lvl goes high.
// Assumes STAGES >= 2.
module tsp_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              lvl_d;

    // Shift the asynchronous pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
    end

    assign lvl = sync_q[STAGES-1] ^ fall_sel;

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;
endmodule

// File: rtl/tsp_prescaler.sv
// Shared prescaler / postscaler counter.
// Owned by the timer (to_wdt = 0): it counts timer source events and
// exposes tap = cnt[ratio], which divides by 2^(ratio+1). Owned by the
// watchdog: it counts wdt_tick_in and passes one tick per 2^ratio.
// The owner's clear strobe zeroes the count.
// Assumes the event strobes are one clock wide.
module tsp_prescaler #(
    parameter int PW = 8,
    parameter int RW = $clog2(PW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          to_wdt,
    input  logic [RW-1:0] ratio,
    input  logic          tmr_evt,
    input  logic          tmr_wr,
    input  logic          wdt_tick_in,
    input  logic          wdt_clr,
    output logic          tap,
    output logic          wdt_tick_out
);
    logic [PW-1:0] cnt;
    logic [PW-1:0] mask;
    logic          step;
    logic          clear;
    logic          post_hit;

    // Route the owner's count and clear strobes to the counter.
    always_comb begin
        step  = to_wdt ? wdt_tick_in : tmr_evt;
        clear = to_wdt ? wdt_clr     : tmr_wr;
    end

    // Low ratio bits all ones marks the last tick of a postscale period.
    always_comb begin
        mask     = (PW'(1) << ratio) - PW'(1);
        post_hit = ((cnt & mask) == mask);
    end

    // Prescale counter: clear has priority over a count step.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (step)  cnt <= cnt + PW'(1);
    end

    assign tap = cnt[ratio];

    // Registered watchdog output; 1:1 while the timer owns the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) wdt_tick_out <= 1'b0;
        else        wdt_tick_out <= wdt_tick_in & (~to_wdt | post_hit);
    end
endmodule

// File: rtl/tsp_q_sampler.sv
// Samples the count signal on Q2 and Q4 edges. A low-to-high change
// seen at either sample requests one timer step on the Q4 edge.
// Assumes ph_q2 and ph_q4 are never high together.
module tsp_q_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_q2,
    input  logic ph_q4,
    input  logic sig,
    output logic inc_req
);
    logic smp;
    logic pend;
    logic rise;

    assign rise = sig & ~smp;

    // Hold the last sampled level between sample points.
    always_ff @(posedge clk) begin
        if (!rst_n)              smp <= 1'b0;
        else if (ph_q2 || ph_q4) smp <= sig;
    end

    // Carry a rise seen at Q2 over to the following Q4.
    always_ff @(posedge clk) begin
        if (!rst_n)             pend <= 1'b0;
        else if (ph_q4)         pend <= 1'b0;
        else if (ph_q2 && rise) pend <= 1'b1;
    end

    assign inc_req = ph_q4 & (pend | rise);
endmodule

// File: rtl/tsp_timer_core.sv
// Timer register with write load, a post-write hold of HOLD Q4 edges,
// wrap-around and a one-cycle overflow pulse.
// Assumes inc_req is only high on Q4 edges.
module tsp_timer_core #(
    parameter int TW   = 8,
    parameter int HOLD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_req,
    input  logic          ph_q4,
    input  logic          wr,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] value,
    output logic          ovf
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] hold;
    logic          step_ok;

    assign step_ok = inc_req && (hold == '0);

    // Timer value: a write wins over a step.
    always_ff @(posedge clk) begin
        if (!rst_n)       value <= '0;
        else if (wr)      value <= wdata;
        else if (step_ok) value <= value + TW'(1);
    end

    // Count down the write hold once per Q4 edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     hold <= '0;
        else if (wr)                    hold <= HW'(HOLD);
        else if (ph_q4 && hold != '0)   hold <= hold - HW'(1);
    end

    // Overflow pulse on the wrap step.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else        ovf <= !wr && step_ok && (value == '1);
    end
endmodule

// File: rtl/timer8_shared_scaler.sv
// Top: 8-bit timer with shared prescaler and phase-sampled clock input.
// Holds the control register and routes the count source. The internal
// source at 1:1 steps directly on Q4. Every other mode goes through the
// Q2/Q4 sampler.
// Assumes ph_q2/ph_q4 come from a free-running four-phase sequencer.
module timer8_shared_scaler
    import tsp_pkg::*;
#(
    parameter int TMR_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int WR_HOLD     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ph_q2,
    input  logic             ph_q4,
    input  logic             ext_clk_in,
    input  logic             ctrl_wr,
    input  logic [CFG_W-1:0] ctrl_data,
    input  logic             tmr_wr,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             wdt_tick_in,
    input  logic             wdt_clr,
    output logic             wdt_tick_out,
    output logic [TMR_W-1:0] tmr_value,
    output logic             tmr_ovf
);
    cfg_t cfg;
    logic ext_lvl;
    logic ext_rise;
    logic src_evt;
    logic tap;
    logic smp_sig;
    logic smp_inc;
    logic inc_req;

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg <= CFG_RESET;
        else if (ctrl_wr) cfg <= cfg_t'(ctrl_data);
    end

    tsp_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_clk_in),
        .fall_sel (cfg.edge_fall),
        .lvl      (ext_lvl),
        .rise     (ext_rise)
    );

    // One source event per instruction cycle or per selected pin edge.
    always_comb begin
        src_evt = cfg.src_ext ? ext_rise : ph_q4;
    end

    tsp_prescaler #(.PW(PRE_BITS), .RW(RATIO_W)) u_pre (
        .clk          (clk),
        .rst_n        (rst_n),
        .to_wdt       (cfg.to_wdt),
        .ratio        (cfg.ratio),
        .tmr_evt      (src_evt),
        .tmr_wr       (tmr_wr),
        .wdt_tick_in  (wdt_tick_in),
        .wdt_clr      (wdt_clr),
        .tap          (tap),
        .wdt_tick_out (wdt_tick_out)
    );

    // Sampler input: prescaler tap when owned, raw pin level otherwise.
    always_comb begin
        smp_sig = cfg.to_wdt ? ext_lvl : tap;
    end

    tsp_q_sampler u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph_q2   (ph_q2),
        .ph_q4   (ph_q4),
        .sig     (smp_sig),
        .inc_req (smp_inc)
    );

    // Internal 1:1 bypasses the sampler; all other modes use it.
    always_comb begin
        inc_req = (cfg.to_wdt && !cfg.src_ext) ? ph_q4 : smp_inc;
    end

    tsp_timer_core #(.TW(TMR_W), .HOLD(WR_HOLD)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_req (inc_req),
        .ph_q4   (ph_q4),
        .wr      (tmr_wr),
        .wdata   (tmr_wdata),
        .value   (tmr_value),
        .ovf     (tmr_ovf)
    );
endmodule

// File: rtl/timer8_shared_scaler_chk.sv
// Port-level checker for timer8_shared_scaler, attached by bind.
// Assumes synchronous active-low reset.
module timer8_shared_scaler_chk #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ph_q4,
    input logic          tmr_wr,
    input logic [TW-1:0] tmr_wdata,
    input logic          wdt_tick_in,
    input logic          wdt_tick_out,
    input logic [TW-1:0] tmr_value,
    input logic          tmr_ovf
);
    p_ovf_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |-> (tmr_value == '0));

    p_ovf_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> !tmr_ovf);

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tmr_wr) && tmr_value != $past(tmr_value))
        |-> (tmr_value == TW'($past(tmr_value) + TW'(1))));

    p_step_at_q4_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tmr_wr) && tmr_value != $past(tmr_value)) |-> $past(ph_q4));

    p_write_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tmr_wr) |-> (tmr_value == $past(tmr_wdata)));

    p_wdt_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tick_out |-> $past(wdt_tick_in));
endmodule

bind timer8_shared_scaler timer8_shared_scaler_chk #(.TW(TMR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ph_q4        (ph_q4),
    .tmr_wr       (tmr_wr),
    .tmr_wdata    (tmr_wdata),
    .wdt_tick_in  (wdt_tick_in),
    .wdt_tick_out (wdt_tick_out),
    .tmr_value    (tmr_value),
    .tmr_ovf      (tmr_ovf)
);

// File: tb/sim_timer8_shared_scaler.sv
`timescale 1ns/1ps
module sim_timer8_shared_scaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ph = 2'd0;
    logic       ext_clk_in = 1'b0, ctrl_wr = 1'b0, tmr_wr = 1'b0;
    logic       wdt_tick_in = 1'b0, wdt_clr = 1'b0;
    logic [5:0] ctrl_data = '0;
    logic [7:0] tmr_wdata = '0;
    logic       wdt_tick_out, tmr_ovf;
    logic [7:0] tmr_value;
    int checks = 0, errors = 0, wd_seen = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // Free-running phase sequencer: ph 0..3 = Q1..Q4 for the coming edge.
    always @(posedge clk) begin
        if (!rst_n) ph <= 2'd0;
        else        ph <= ph + 2'd1;
    end

    timer8_shared_scaler u0 (
        .clk(clk), .rst_n(rst_n), .ph_q2(ph == 2'd1), .ph_q4(ph == 2'd3),
        .ext_clk_in(ext_clk_in), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .wdt_tick_in(wdt_tick_in),
        .wdt_clr(wdt_clr), .wdt_tick_out(wdt_tick_out),
        .tmr_value(tmr_value), .tmr_ovf(tmr_ovf));

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            if (wdt_tick_out) wd_seen++;
        end
    endtask

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [5:0] mk(input bit e, input bit s, input bit a, input int r);
        return {e, s, a, 3'(r)};
    endfunction

    task automatic cfg_write(input logic [5:0] v);
        ctrl_data = v; ctrl_wr = 1'b1; tick(1); ctrl_wr = 1'b0;
    endtask

    task automatic tmr_write(input logic [7:0] v);
        tmr_wdata = v; tmr_wr = 1'b1; tick(1); tmr_wr = 1'b0;
    endtask

    task automatic wdt_clear();
        wdt_clr = 1'b1; tick(1); wdt_clr = 1'b0;
    endtask

    task automatic wdt_pulses(input int n);
        repeat (n) begin wdt_tick_in = 1'b1; tick(1); wdt_tick_in = 1'b0; tick(1); end
    endtask

    task automatic ext_pulses(input int n, input int h, input int l);
        repeat (n) begin ext_clk_in = 1'b1; tick(h); ext_clk_in = 1'b0; tick(l); end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v0, v1, j, ovf_n, ovf_bad;
        tick(3);
        // R1: reset state at the ports
        chk(tmr_value == 0 && !tmr_ovf && !wdt_tick_out, "R1 reset outputs",
            {tmr_value, 7'(tmr_ovf), 1'(wdt_tick_out)}, 0);
        rst_n = 1'b1;
        tick(1);
        chk(tmr_value == 0, "R1 value at release", tmr_value, 0);
        // R1: default internal 1:1 counting
        tick(3); v0 = tmr_value; tick(16); v1 = tmr_value;
        chk(8'(v1 - v0) == 4, "R1/R3 default 1:1 rate", 8'(v1 - v0), 4);
        // R1: default postscaler 1:128 from a zero count
        wd_seen = 0; wdt_pulses(128); tick(2);
        chk(wd_seen == 1, "R1/R7 default postscale", wd_seen, 1);

        // R5: write hold, then one step per instruction cycle
        cfg_write(mk(0, 0, 1, 0));
        tmr_write(8'h10);
        tick(4);  chk(tmr_value == 8'h10, "R5 hold n=1", tmr_value, 16);
        tick(4);  chk(tmr_value == 8'h10, "R5 hold n=2", tmr_value, 16);
        tick(4);  chk(tmr_value == 8'h11, "R5 resume n=3", tmr_value, 17);
        tick(4);  chk(tmr_value == 8'h12, "R3 step n=4", tmr_value, 18);

        // R12: wrap and single overflow pulse
        tmr_write(8'hFD);
        ovf_n = 0; ovf_bad = 0;
        for (int k = 1; k <= 24; k++) begin
            tick(1);
            if (tmr_ovf) begin ovf_n++; if (tmr_value != 0) ovf_bad++; end
            if (k == 16) chk(tmr_value == 8'hFF, "R12 before wrap", tmr_value, 255);
            if (k == 20) chk(tmr_value == 8'h00, "R12 wrapped", tmr_value, 0);
        end
        chk(ovf_n == 1 && ovf_bad == 0, "R12 overflow pulse count", ovf_n, 1);

        // R2/R4: timer prescale sweep, internal source
        for (int r = 0; r < 8; r++) begin
            cfg_write(mk(0, 0, 0, r));
            tmr_write(8'h00); tick(16);
            v0 = tmr_value; tick(8 * (2 << r)); v1 = tmr_value;
            chk(8'(v1 - v0) == 2, $sformatf("R4 internal ratio %0d", r), 8'(v1 - v0), 2);
        end

        // R6: timer writes clear the prescaler while the timer owns it
        cfg_write(mk(0, 0, 0, 2));
        v0 = 0;
        for (int k = 0; k < 20; k++) begin
            tmr_write(8'h40); tick(11);
            if (tmr_value != 8'h40) v0++;
        end
        chk(v0 == 0, "R6 write clears prescaler", v0, 0);

        // R8: wdt_clr has no effect while the timer owns the prescaler
        tmr_write(8'h00); tick(16); v0 = tmr_value;
        repeat (8) begin wdt_clear(); tick(15); end
        v1 = tmr_value;
        chk(8'(v1 - v0) == 4, "R8 wdt_clr ignored by timer prescaler", 8'(v1 - v0), 4);

        // R7: postscaler sweep
        for (int r = 0; r < 8; r++) begin
            cfg_write(mk(0, 0, 1, r));
            wdt_clear(); wd_seen = 0;
            wdt_pulses(2 << r); tick(2);
            chk(wd_seen == 2, $sformatf("R7 postscale ratio %0d", r), wd_seen, 2);
        end
        cfg_write(mk(0, 0, 0, 5));
        wd_seen = 0; wdt_pulses(5); tick(2);
        chk(wd_seen == 5, "R7 1:1 when timer owns", wd_seen, 5);

        // R8: wdt_clr clears the postscaler
        cfg_write(mk(0, 0, 1, 3));
        wdt_clear(); wd_seen = 0;
        wdt_pulses(5); wdt_clear(); wdt_pulses(5); tick(2);
        chk(wd_seen == 0, "R8 clear restarts postscale", wd_seen, 0);
        wdt_pulses(3); tick(2);
        chk(wd_seen == 1, "R8 postscale after clear", wd_seen, 1);
        // R6: timer write leaves the postscaler alone
        wdt_clear(); wd_seen = 0;
        wdt_pulses(5); tmr_write(8'h22); wdt_pulses(3); tick(2);
        chk(wd_seen == 1, "R6 write keeps postscaler", wd_seen, 1);

        // R9: internal source ignores the pin
        cfg_write(mk(0, 0, 1, 0));
        tmr_write(8'h00); tick(16); v0 = tmr_value;
        ext_pulses(8, 2, 2); v1 = tmr_value;
        chk(8'(v1 - v0) == 8, "R9 pin ignored on internal source", 8'(v1 - v0), 8);

        // R9: external, no prescaler, pulse shape and edge sweep
        for (int e = 0; e < 2; e++)
            for (int h = 2; h <= 5; h++)
                for (int l = 2; l <= 5; l++) begin
                    cfg_write(mk(e[0], 1, 1, 0));
                    tmr_write(8'h00); tick(16); v0 = tmr_value;
                    ext_pulses(10, h, l); tick(16); v1 = tmr_value;
                    chk(8'(v1 - v0) == 10,
                        $sformatf("R9 edge %0d high %0d low %0d", e, h, l), 8'(v1 - v0), 10);
                end

        // R4: external source through the prescaler
        for (int r = 0; r < 4; r++) begin
            cfg_write(mk(0, 1, 0, r));
            tmr_write(8'h00); tick(16); v0 = tmr_value;
            ext_pulses(3 * (2 << r), 2, 2); tick(16); v1 = tmr_value;
            chk(8'(v1 - v0) == 3, $sformatf("R4 external ratio %0d", r), 8'(v1 - v0), 3);
        end

        // R10: edge-to-step latency for each phase alignment
        cfg_write(mk(0, 1, 1, 0));
        tmr_write(8'h00); tick(16);
        for (int a = 0; a < 4; a++) begin
            while (ph != 2'(a)) tick(1);
            v0 = tmr_value;
            ext_clk_in = 1'b1;
            case ((a + 2) % 4)
                3: j = 2;
                2: j = 3;
                1: j = 4;
                default: j = 5;
            endcase
            tick(j);
            chk(tmr_value == 8'(v0), $sformatf("R10 no step before edge %0d", j), tmr_value, v0);
            tick(1);
            chk(tmr_value == 8'(v0 + 1), $sformatf("R10 step at edge %0d", j), tmr_value, v0 + 1);
            ext_clk_in = 1'b0; tick(12);
        end

        // R11: one-clock pulses that only meet Q1/Q3 sample edges are missed
        v0 = tmr_value;
        for (int k = 0; k < 8; k++) begin
            while (ph != ((k % 2 == 0) ? 2'd0 : 2'd2)) tick(1);
            ext_clk_in = 1'b1; tick(1); ext_clk_in = 1'b0; tick(7);
        end
        chk(tmr_value == 8'(v0), "R11 short pulses missed", tmr_value, v0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule